// File: doc/BRIEF.md
# Framed Serial Converter Port

This block is the device-side serial port of a 10-bit sampling converter. It runs on a fast system clock and oversamples the external serial clock, the two frame-sync lines and the data input. It handles two kinds of frame, and each kind has its own sync line.

- **Write frame.** An active-low write sync opens the frame. The port then collects a 10-bit control word from the data line and stores it in a control register.
- **Read frame.** A rising edge on the read sync arms the read side. The port then shifts out a 10-bit conversion result. The data output has an enable that tells the pad when to drive.

A hardwired package address input works with an address bit inside the control word. This lets two devices share one bus and be addressed separately. A write only changes the register when the address bit in the word matches the package address input. A read only drives the pin when the stored address bit matches.

The analog front end and the conversion engine lie outside this block. The result arrives as a parallel word, and the control word leaves as a parallel word with a one-cycle strobe.

Top module: `cvt_serial_port`

## Requirements
- R1: After reset, the control word is 0, the strobe is low, the output enable is low and the data output is 0.
- R2: A falling edge on `wsync_n_i` opens a write frame. Each of the next 10 falling edges of `sclk_i` shifts in one `din_i` bit. The first bit is taken as word bit 9 and the tenth as bit 0.
- R3: A write frame lasts 13 falling `sclk_i` edges. Bits 11 to 13 change nothing. Falling `sclk_i` edges outside a write frame also change nothing.
- R4: Bit 9 of the control word is the address bit. A frame whose bit 9 differs from `pkg_addr_i` leaves the control word unchanged and raises no strobe.
- R5: When a matching 10th bit is taken, `ctrl_stb_o` is high for exactly one system clock. In that same cycle `ctrl_word_o` carries the new word, and the word changes at no other time.
- R6: The read side ignores `sclk_i` until `rsync_i` rises. That rising edge takes a snapshot of `result_i`, and later changes on `result_i` do not affect the frame.
- R7: The k-th rising `sclk_i` edge of a read (k = 1 to 10) drives result bit 10-k on `dout_o`. `dout_o` changes only after a rising `sclk_i` edge.
- R8: The 11th rising `sclk_i` edge of a read drops `dout_oe_o` and ends the frame. Further rising edges leave the output released until the next `rsync_i` rising edge.
- R9: During a read, `dout_oe_o` is high only if bit 9 of the stored control word equals `pkg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | External serial clock |
| wsync_n_i | input | 1 | Write frame sync, falling edge opens a write |
| rsync_i | input | 1 | Read frame sync, rising edge arms a read |
| din_i | input | 1 | Serial control data |
| pkg_addr_i | input | 1 | Hardwired package address |
| result_i | input | 10 | Latest conversion result |
| ctrl_word_o | output | 10 | Stored control word |
| ctrl_stb_o | output | 1 | One-cycle strobe when the control word is updated |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Drive enable for the data pin |

## Verification
The assertions rely on three assumptions about the inputs:

- `sclk_i` runs at no more than one eighth of the system clock.
- Every line holds steady long enough to pass through the two-flop synchronizer.
- `pkg_addr_i` changes only between frames.

The stimulus keeps within these limits. It holds each serial clock phase for eight system clocks and changes the data line only while the serial clock is low. It changes the package address only when both frames are idle. Random words, results and address values from a fixed seed are mixed with directed cases: a mismatched address, edges outside any frame, and a result that changes after the read is armed.

// File: rtl/cvt_port_pkg.sv
package cvt_port_pkg;
  localparam int unsigned LINE_SCLK = 0;
  localparam int unsigned LINE_WSYNC = 1;
  localparam int unsigned LINE_RSYNC = 2;
  localparam int unsigned LINE_DIN = 3;
  localparam int unsigned LINE_COUNT = 4;

  // shift one serial bit into the low end of a word (MSB-first transfer)
  function automatic logic [15:0] shift_in(input logic [15:0] word, input logic bit_in);
    return {word[14:0], bit_in};
  endfunction

  // the top bit of a word is its address bit
  function automatic logic addr_hit(input logic addr_bit, input logic pkg_addr);
    return addr_bit == pkg_addr;
  endfunction
endpackage

// File: rtl/cvt_line_sync.sv
module cvt_line_sync #(
  parameter int unsigned N = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] idle_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {(STAGES+1){idle_i[g]}};
      else        pipe <= {pipe[STAGES-1:0], line_i[g]};
    end
    assign level_o[g] = pipe[STAGES-1];
    assign rise_o[g]  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall_o[g]  = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/cvt_write_framer.sv
module cvt_write_framer
  import cvt_port_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned FRAME_PULSES = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              sclk_fall_i,
  input  logic              din_i,
  input  logic              pkg_addr_i,
  output logic [DATA_W-1:0] ctrl_q_o,
  output logic              ctrl_stb_o
);
  localparam int unsigned CW = $clog2(FRAME_PULSES + 1);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LAST_PULSE = CW'(FRAME_PULSES - 1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_word;
  logic              bit_take;
  logic              word_done;

  assign next_word = DATA_W'(shift_in(16'(shreg), din_i));
  assign bit_take  = active && sclk_fall_i && (cnt < CW'(DATA_W));
  assign word_done = active && sclk_fall_i && (cnt == LAST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      ctrl_q_o   <= '0;
      ctrl_stb_o <= 1'b0;
    end else begin
      ctrl_stb_o <= 1'b0;
      if (frame_start_i) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && sclk_fall_i) begin
        cnt <= cnt + 1'b1;
        if (bit_take) shreg <= next_word;
        if (word_done && addr_hit(next_word[DATA_W-1], pkg_addr_i)) begin
          ctrl_q_o   <= next_word;
          ctrl_stb_o <= 1'b1;
        end
        if (cnt == LAST_PULSE) active <= 1'b0;
      end
    end
  end

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |=> !ctrl_stb_o);
  assert_word_moves_with_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q_o) |-> ctrl_stb_o);
  assert_stb_addr_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_stb_o |-> (ctrl_q_o[DATA_W-1] == pkg_addr_i));
  assert_frame_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME_PULSES));
endmodule

// File: rtl/cvt_read_shifter.sv
module cvt_read_shifter #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              sclk_rise_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              addr_ok_i,
  output logic              dout_o,
  output logic              dout_oe_o
);
  localparam int unsigned CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] RELEASE_AT = CW'(DATA_W);

  logic              armed;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic              bit_step;
  logic              release_step;

  assign bit_step     = armed && sclk_rise_i && (cnt < RELEASE_AT);
  assign release_step = armed && sclk_rise_i && (cnt == RELEASE_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
      dout_o    <= 1'b0;
      dout_oe_o <= 1'b0;
    end else if (arm_i) begin
      armed     <= 1'b1;
      cnt       <= '0;
      shreg     <= result_i;
      dout_oe_o <= 1'b0;
    end else if (bit_step) begin
      cnt       <= cnt + 1'b1;
      dout_o    <= shreg[DATA_W-1];
      shreg     <= {shreg[DATA_W-2:0], 1'b0};
      dout_oe_o <= addr_ok_i;
    end else if (release_step) begin
      armed     <= 1'b0;
      cnt       <= '0;
      dout_oe_o <= 1'b0;
    end
  end

  assert_dout_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout_o) |-> $past(sclk_rise_i));
  assert_oe_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe_o) |-> $past(sclk_rise_i));
  assert_oe_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe_o |-> armed);
  assert_oe_needs_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe_o) |-> $past(addr_ok_i));
endmodule

// File: rtl/cvt_serial_port.sv
module cvt_serial_port
  import cvt_port_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned WR_PULSES = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              wsync_n_i,
  input  logic              rsync_i,
  input  logic              din_i,
  input  logic              pkg_addr_i,
  input  logic [DATA_W-1:0] result_i,
  output logic [DATA_W-1:0] ctrl_word_o,
  output logic              ctrl_stb_o,
  output logic              dout_o,
  output logic              dout_oe_o
);
  logic [LINE_COUNT-1:0] lines, idle, lvl, rise, fall;
  logic addr_ok;

  assign lines[LINE_SCLK]  = sclk_i;
  assign lines[LINE_WSYNC] = wsync_n_i;
  assign lines[LINE_RSYNC] = rsync_i;
  assign lines[LINE_DIN]   = din_i;

  assign idle[LINE_SCLK]  = 1'b0;
  assign idle[LINE_WSYNC] = 1'b1;
  assign idle[LINE_RSYNC] = 1'b0;
  assign idle[LINE_DIN]   = 1'b0;

  cvt_line_sync #(.N(LINE_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .idle_i(idle),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  cvt_write_framer #(.DATA_W(DATA_W), .FRAME_PULSES(WR_PULSES)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(fall[LINE_WSYNC]),
    .sclk_fall_i(fall[LINE_SCLK]),
    .din_i(lvl[LINE_DIN]),
    .pkg_addr_i(pkg_addr_i),
    .ctrl_q_o(ctrl_word_o),
    .ctrl_stb_o(ctrl_stb_o)
  );

  assign addr_ok = addr_hit(ctrl_word_o[DATA_W-1], pkg_addr_i);

  cvt_read_shifter #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arm_i(rise[LINE_RSYNC]),
    .sclk_rise_i(rise[LINE_SCLK]),
    .result_i(result_i),
    .addr_ok_i(addr_ok),
    .dout_o(dout_o),
    .dout_oe_o(dout_oe_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!ctrl_stb_o && !dout_oe_o));
endmodule

// File: tb/cvt_serial_port_bench.sv
module cvt_serial_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, wsync_n = 1'b1, rsync = 1'b0, din = 1'b0, pkg_addr = 1'b0;
  logic [9:0] result = '0;
  logic [9:0] ctrl_word;
  logic ctrl_stb, dout, dout_oe;

  int total = 0, bad = 0, stb_seen = 0;
  logic [9:0] stb_word = '0;
  logic [9:0] m_ctrl = '0;
  bit done = 0;

  always #5 clk = ~clk;

  cvt_serial_port u_cvt_serial_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .wsync_n_i(wsync_n), .rsync_i(rsync),
    .din_i(din), .pkg_addr_i(pkg_addr), .result_i(result),
    .ctrl_word_o(ctrl_word), .ctrl_stb_o(ctrl_stb), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  always @(posedge clk) if (ctrl_stb) begin
    stb_seen <= stb_seen + 1;
    stb_word <= ctrl_word;
  end

  function automatic logic exp_bit(input logic [9:0] w, input int k);
    return w[10 - k];
  endfunction

  function automatic logic exp_update(input logic [9:0] w, input logic pa);
    return w[9] == pa;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic d);
    @(negedge clk); din = d;
    wait_clk(2); sclk = 1'b1;
    wait_clk(8); sclk = 1'b0;
    wait_clk(8);
  endtask

  task automatic do_write(input logic [9:0] w, input logic [2:0] tail);
    int s0;
    logic upd;
    s0 = stb_seen;
    upd = exp_update(w, pkg_addr);
    @(negedge clk); wsync_n = 1'b0;
    wait_clk(6);
    for (int k = 9; k >= 0; k--) pulse(w[k]);
    for (int k = 2; k >= 0; k--) pulse(tail[k]);
    wsync_n = 1'b1;
    wait_clk(6);
    if (upd) m_ctrl = w;
    check("R4 control word", 32'(ctrl_word), 32'(m_ctrl));
    check("R5 strobe count", 32'(stb_seen - s0), upd ? 32'd1 : 32'd0);
    if (upd) check("R5 strobe word", 32'(stb_word), 32'(w));
  endtask

  task automatic do_read(input logic [9:0] r, input logic [9:0] junk);
    logic drv;
    drv = (m_ctrl[9] == pkg_addr);
    @(negedge clk); result = r; rsync = 1'b1;
    wait_clk(8);
    result = junk;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); sclk = 1'b1;
      wait_clk(6);
      if (k <= 10) begin
        check("R9 drive enable", 32'(dout_oe), 32'(drv));
        if (drv) check("R7 R6 data bit", 32'(dout), 32'(exp_bit(r, k)));
      end else begin
        check("R8 released", 32'(dout_oe), 32'd0);
      end
      wait_clk(2); sclk = 1'b0;
      wait_clk(8);
    end
    rsync = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    wait_clk(4);
    check("R1 ctrl", 32'(ctrl_word), 32'd0);
    check("R1 stb", 32'(ctrl_stb), 32'd0);
    check("R1 oe", 32'(dout_oe), 32'd0);
    check("R1 dout", 32'(dout), 32'd0);
    rst_n = 1'b1;
    wait_clk(4);

    // R6: clocks before any read sync rising edge keep the pin released
    for (int k = 0; k < 3; k++) begin
      pulse(1'b1);
      check("R6 no arm", 32'(dout_oe), 32'd0);
    end
    // R3: falling edges outside a write frame change nothing
    for (int k = 0; k < 12; k++) pulse(k[0]);
    check("R3 no frame ctrl", 32'(ctrl_word), 32'd0);
    check("R3 no frame stb", 32'(stb_seen), 32'd0);

    // directed R2: matching write with address bit 0
    do_write(10'b0_101100111, 3'b111);
    check("R2 msb first", 32'(ctrl_word), 32'h167);
    // R3: trailing clocks after a closed frame
    for (int k = 0; k < 4; k++) pulse(1'b1);
    check("R3 after frame", 32'(ctrl_word), 32'h167);
    do_read(10'h2A5, 10'h000);
    // R4: mismatched address leaves the register alone
    do_write(10'b1_000011110, 3'b000);
    // R9: other package address no longer matches stored bit
    pkg_addr = 1'b1;
    wait_clk(4);
    do_read(10'h3C3, 10'h3FF);
    do_write(10'b1_110001011, 3'b010);
    do_read(10'h155, 10'h0AA);

    for (int i = 0; i < 24; i++) begin
      logic [9:0] w, r, j;
      w = 10'($urandom);
      r = 10'($urandom);
      j = 10'($urandom);
      if (($urandom % 4) == 0) begin
        pkg_addr = 1'($urandom);
        wait_clk(4);
      end
      do_write(w, 3'($urandom));
      do_read(r, j);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule